// File: doc/BRIEF.md
# Timer Time-Base Counter

This block is the counting core of a general-purpose timer. It advances a counter on count-enable pulses from an external prescaler. The counter can count upward, downward, or up and down in a triangle. Each time the counter wraps, the block can raise an update event. A repetition divider thins these events out. An update event also copies a pending reload value into the active reload register. Software can force an update, suppress updates, or make forced updates quiet. A sticky flag, gated by an enable, drives the interrupt request.

The block holds the current counting direction in a two-state machine. The states are `CNT_UP` and `CNT_DOWN`, and these transitions move between them:

- `T_FOLLOW`: in the edge modes, the state tracks the software direction bit.
- `T_TURN_DOWN`: in centre mode, reaching the top moves the state to `CNT_DOWN`.
- `T_TURN_UP`: in centre mode, reaching zero moves the state to `CNT_UP`.
- `T_RESTART`: a software update sets the restart direction.

Software talks to the block through a single-cycle write port and a combinational read port. The counter value, the direction, the event pulse, the flag, the interrupt request and a prescaler-restart pulse are also available as direct outputs. `CNT_W` must be at least 8, and `REP_W` must not exceed `CNT_W`.

Top module: `tmr_timebase`

## Requirements
- R1: Reset state: the counter is 0, the direction is up, the flag is 0, the interrupt request is 0, and the event pulse is 0. The pending and active reload values are all ones, and the repetition value is 0.
- R2: The counter changes only on a clock where `tick_i` is 1 and the run bit (control bit 0) is 1, or on a software update. Ticks arriving while the run bit is 0 leave the counter unchanged.
- R3: Up mode is control bits 3:2 = 00 with control bit 1 = 0. The counter steps from 0 to the reload value. On the next tick it returns to 0 and, if updates are allowed, raises a one-cycle event pulse.
- R4: Down mode is control bits 3:2 = 00 with control bit 1 = 1. The counter steps down to 0. On the next tick it reloads the reload value and raises an event.
- R5: Centre mode is any nonzero value in control bits 3:2. From the top the counter turns to reload-1 with an overflow event. From 0 it turns to 1 with an underflow event. Control bit 1 is ignored in this mode, and `dir_o` (1 = down) shows the hardware direction.
- R6: The repetition value N causes an event on only every (N+1)-th wrap. The repetition countdown reloads N at every update event.
- R7: With the preload bit (control bit 4) at 0, a written reload value takes effect at once. With the preload bit at 1, the new value becomes active only at the next update event. A down-mode or centre-mode wrap that performs the update already uses the new value for the next period.
- R8: With the update-disable bit (control bit 5) at 1, wraps give no event and no flag, and the active reload is not refreshed. The counter keeps wrapping on the active value.
- R9: Writing 1 to bit 0 at address 3 forces an update event and a one-cycle `psc_clr_o` pulse. It restarts the counter at 0 in up and centre modes, and at the reload value in down mode.
- R10: With the quiet bit (control bit 6) at 1, a software update still reloads the active reload value and pulses the event output, but it does not set the flag.
- R11: The flag stays set until software writes 1 to bit 0 at address 4. If a flag-setting update coincides with that clear, the flag stays set. `irq_o` is the flag ANDed with the interrupt-enable bit (control bit 7).
- R12: Reading returns the following, with unused bits 0:
  - address 0: control, with bit 1 showing the current direction;
  - address 1: the pending reload value;
  - address 2: the repetition value;
  - address 4: the flag in bit 0;
  - address 5: the counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | Count-enable pulse from the prescaler |
| bus_we_i | input | 1 | Write strobe |
| bus_waddr_i | input | ADDR_W | Write address |
| bus_wdata_i | input | CNT_W | Write data |
| bus_raddr_i | input | ADDR_W | Read address |
| bus_rdata_o | output | CNT_W | Read data (combinational) |
| cnt_o | output | CNT_W | Counter value |
| dir_o | output | 1 | Current direction, 1 = down |
| uev_o | output | 1 | One-cycle update event pulse |
| uflag_o | output | 1 | Sticky update flag |
| irq_o | output | 1 | Interrupt request |
| psc_clr_o | output | 1 | One-cycle prescaler restart pulse |

## Verification
The bench instantiates the block with `CNT_W = 8` and `REP_W = 4`.

The narrow counter puts the all-ones reload value within reach. A full run from 0 to 255 and back to 0 fits in a few hundred ticks, so the bench can check the top boundary directly.

Small reload values of 1 to 5 keep every mode's wrap short. This lets the bench observe these cases cycle by cycle:

- repetition-gated events;
- deferred preload;
- the effect of the update-disable bit;
- centre-mode turnarounds.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

    typedef enum logic [0:0] {
        CNT_UP   = 1'b0,
        CNT_DOWN = 1'b1
    } dir_e;

    typedef struct packed {
        logic       irq_en;
        logic       quiet_sw;
        logic       upd_off;
        logic       preload;
        logic [1:0] center;
        logic       down;
        logic       run;
    } ctrl_t;

    localparam int A_CTRL   = 0;
    localparam int A_RELOAD = 1;
    localparam int A_REPEAT = 2;
    localparam int A_EVENT  = 3;
    localparam int A_STATUS = 4;
    localparam int A_COUNT  = 5;

endpackage

// File: rtl/tmr_regs.sv
module tmr_regs
    import tmr_pkg::*;
#(
    parameter int CNT_W  = 16,
    parameter int REP_W  = 8,
    parameter int ADDR_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we_i,
    input  logic [ADDR_W-1:0] waddr_i,
    input  logic [CNT_W-1:0]  wdata_i,
    input  logic [ADDR_W-1:0] raddr_i,
    input  logic [CNT_W-1:0]  cnt_i,
    input  logic              down_i,
    input  logic              flag_i,
    output ctrl_t             ctrl_o,
    output logic [CNT_W-1:0]  reload_o,
    output logic [REP_W-1:0]  repeat_o,
    output logic              sw_upd_o,
    output logic              flag_clr_o,
    output logic [CNT_W-1:0]  rdata_o
);

    localparam logic [ADDR_W-1:0] AD_CTRL   = ADDR_W'(A_CTRL);
    localparam logic [ADDR_W-1:0] AD_RELOAD = ADDR_W'(A_RELOAD);
    localparam logic [ADDR_W-1:0] AD_REPEAT = ADDR_W'(A_REPEAT);
    localparam logic [ADDR_W-1:0] AD_EVENT  = ADDR_W'(A_EVENT);
    localparam logic [ADDR_W-1:0] AD_STATUS = ADDR_W'(A_STATUS);
    localparam logic [ADDR_W-1:0] AD_COUNT  = ADDR_W'(A_COUNT);

    ctrl_t             ctrl_q;
    logic [CNT_W-1:0]  reload_q;
    logic [REP_W-1:0]  repeat_q;
    logic [7:0]        cbits;

    // Stored registers; writes land in one cycle.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q   <= '0;
            reload_q <= '1;
            repeat_q <= '0;
        end else if (we_i) begin
            case (waddr_i)
                AD_CTRL:   ctrl_q   <= ctrl_t'(wdata_i[7:0]);
                AD_RELOAD: reload_q <= wdata_i;
                AD_REPEAT: repeat_q <= wdata_i[REP_W-1:0];
                default:   ;
            endcase
        end
    end

    // Strobe-type addresses produce single-cycle pulses.
    assign sw_upd_o   = we_i && (waddr_i == AD_EVENT)  && wdata_i[0];
    assign flag_clr_o = we_i && (waddr_i == AD_STATUS) && wdata_i[0];

    assign ctrl_o   = ctrl_q;
    assign reload_o = reload_q;
    assign repeat_o = repeat_q;
    assign cbits    = ctrl_q;

    // Read mux; the direction bit reflects hardware state.
    always_comb begin
        rdata_o = '0;
        case (raddr_i)
            AD_CTRL:   rdata_o[7:0]       = {cbits[7:2], down_i, cbits[0]};
            AD_RELOAD: rdata_o            = reload_q;
            AD_REPEAT: rdata_o[REP_W-1:0] = repeat_q;
            AD_STATUS: rdata_o[0]         = flag_i;
            AD_COUNT:  rdata_o            = cnt_i;
            default:   rdata_o            = '0;
        endcase
    end

endmodule

// File: rtl/tmr_dir_fsm.sv
module tmr_dir_fsm
    import tmr_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic center_i,
    input  logic down_sel_i,
    input  logic sw_upd_i,
    input  logic hit_top_i,
    input  logic hit_bot_i,
    output dir_e state_o,
    output logic down_o
);

    dir_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= CNT_UP;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        if (sw_upd_i) begin
            // T_RESTART
            state_d = (!center_i && down_sel_i) ? CNT_DOWN : CNT_UP;
        end else if (!center_i) begin
            // T_FOLLOW
            state_d = down_sel_i ? CNT_DOWN : CNT_UP;
        end else begin
            unique case (state_q)
                CNT_UP:   if (hit_top_i) state_d = CNT_DOWN;  // T_TURN_DOWN
                CNT_DOWN: if (hit_bot_i) state_d = CNT_UP;    // T_TURN_UP
            endcase
        end
    end

    always_comb begin
        state_o = state_q;
        down_o  = (state_q == CNT_DOWN);
    end

    // R5: in centre mode the direction only turns at an end point
    a_r5_turn_only_at_ends: assert property (@(posedge clk) disable iff (!rst_n)
        (center_i && !hit_top_i && !hit_bot_i && !sw_upd_i) |=> $stable(state_q));

    // R5: reaching the top in centre mode turns the count downward
    a_r5_top_turns_down: assert property (@(posedge clk) disable iff (!rst_n)
        (center_i && hit_top_i && !sw_upd_i) |=> (state_q == CNT_DOWN));

endmodule

// File: rtl/tmr_core.sv
module tmr_core
    import tmr_pkg::*;
#(
    parameter int CNT_W = 16,
    parameter int REP_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_i,
    input  logic             run_i,
    input  logic [1:0]       center_i,
    input  logic             down_sel_i,
    input  logic             preload_i,
    input  logic             upd_off_i,
    input  logic             quiet_i,
    input  logic [CNT_W-1:0] reload_i,
    input  logic [REP_W-1:0] repeat_i,
    input  logic             sw_upd_i,
    input  logic             flag_clr_i,
    input  dir_e             state_i,
    output logic [CNT_W-1:0] cnt_o,
    output logic             hit_top_o,
    output logic             hit_bot_o,
    output logic             uev_o,
    output logic             flag_o,
    output logic             psc_clr_o
);

    logic [CNT_W-1:0] cnt_q, cnt_d, ar_act_q, ar_cur, ar_eff;
    logic [REP_W-1:0] rep_q;
    logic             step, is_center, top_hit, bot_hit, wrap;
    logic             rep_empty, hw_upd, any_upd, load_shadow, set_flag;
    logic             uev_q, flag_q, psc_q;

    assign step      = run_i & tick_i;
    assign is_center = (center_i != 2'b00);

    // Without preload the written value is live at once.
    assign ar_cur    = preload_i ? ar_act_q : reload_i;

    assign top_hit   = step && (state_i == CNT_UP)   && (cnt_q >= ar_cur);
    assign bot_hit   = step && (state_i == CNT_DOWN) && (cnt_q == '0);
    assign wrap      = top_hit | bot_hit;

    assign rep_empty   = (rep_q == '0);
    assign hw_upd      = wrap & ~upd_off_i & rep_empty;
    assign any_upd     = hw_upd | sw_upd_i;
    assign load_shadow = ~preload_i | any_upd;
    assign ar_eff      = load_shadow ? reload_i : ar_act_q;
    assign set_flag    = hw_upd | (sw_upd_i & ~quiet_i);

    // Next counter value.
    always_comb begin
        cnt_d = cnt_q;
        if (sw_upd_i) begin
            cnt_d = (!is_center && down_sel_i) ? ar_eff : '0;
        end else if (step) begin
            unique case (state_i)
                CNT_UP: begin
                    if (cnt_q >= ar_cur)
                        cnt_d = is_center ? ((ar_eff == '0) ? '0 : ar_eff - 1'b1) : '0;
                    else
                        cnt_d = cnt_q + 1'b1;
                end
                CNT_DOWN: begin
                    if (cnt_q == '0)
                        cnt_d = is_center ? ((ar_eff == '0) ? '0 : CNT_W'(1)) : ar_eff;
                    else
                        cnt_d = cnt_q - 1'b1;
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q    <= '0;
            ar_act_q <= '1;
            rep_q    <= '0;
            uev_q    <= 1'b0;
            flag_q   <= 1'b0;
            psc_q    <= 1'b0;
        end else begin
            cnt_q <= cnt_d;
            if (load_shadow) ar_act_q <= reload_i;
            if (any_upd)
                rep_q <= repeat_i;
            else if (wrap && !upd_off_i)
                rep_q <= rep_q - 1'b1;
            uev_q <= any_upd;
            psc_q <= sw_upd_i;
            if (set_flag)        flag_q <= 1'b1;
            else if (flag_clr_i) flag_q <= 1'b0;
        end
    end

    assign cnt_o     = cnt_q;
    assign hit_top_o = top_hit;
    assign hit_bot_o = bot_hit;
    assign uev_o     = uev_q;
    assign flag_o    = flag_q;
    assign psc_clr_o = psc_q;

    // R2: no tick and no forced update leaves the counter still
    a_r2_hold_without_step: assert property (@(posedge clk) disable iff (!rst_n)
        (!step && !sw_upd_i) |=> $stable(cnt_q));

    // R3: an edge-mode top wrap returns the counter to zero
    a_r3_up_wraps_to_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (!is_center && top_hit && !sw_upd_i) |=> (cnt_q == '0));

    // R6: a wrap with repetitions left produces no event
    a_r6_rep_gates_event: assert property (@(posedge clk) disable iff (!rst_n)
        (wrap && !rep_empty && !sw_upd_i) |=> !uev_q);

    // R8: update disable suppresses hardware events
    a_r8_no_event_when_off: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_off_i && !sw_upd_i) |=> !uev_q);

    // R9: a forced update always pulses the event and prescaler restart
    a_r9_sw_forces_event: assert property (@(posedge clk) disable iff (!rst_n)
        sw_upd_i |=> (uev_q && psc_q));

    // R10: a quiet forced update leaves a clear flag clear
    a_r10_quiet_keeps_flag: assert property (@(posedge clk) disable iff (!rst_n)
        (sw_upd_i && quiet_i && !wrap && !flag_q) |=> !flag_q);

    // R11: the flag holds until a clear arrives
    a_r11_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_q && !flag_clr_i) |=> flag_q);

endmodule

// File: rtl/tmr_timebase.sv
module tmr_timebase
    import tmr_pkg::*;
#(
    parameter int CNT_W  = 16,
    parameter int REP_W  = 8,
    parameter int ADDR_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_i,
    input  logic              bus_we_i,
    input  logic [ADDR_W-1:0] bus_waddr_i,
    input  logic [CNT_W-1:0]  bus_wdata_i,
    input  logic [ADDR_W-1:0] bus_raddr_i,
    output logic [CNT_W-1:0]  bus_rdata_o,
    output logic [CNT_W-1:0]  cnt_o,
    output logic              dir_o,
    output logic              uev_o,
    output logic              uflag_o,
    output logic              irq_o,
    output logic              psc_clr_o
);

    ctrl_t            ctrl;
    logic [CNT_W-1:0] reload, cnt;
    logic [REP_W-1:0] rep_val;
    logic             sw_upd, flag_clr, hit_top, hit_bot, flag, down;
    dir_e             state;

    tmr_regs #(.CNT_W(CNT_W), .REP_W(REP_W), .ADDR_W(ADDR_W)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .we_i       (bus_we_i),
        .waddr_i    (bus_waddr_i),
        .wdata_i    (bus_wdata_i),
        .raddr_i    (bus_raddr_i),
        .cnt_i      (cnt),
        .down_i     (down),
        .flag_i     (flag),
        .ctrl_o     (ctrl),
        .reload_o   (reload),
        .repeat_o   (rep_val),
        .sw_upd_o   (sw_upd),
        .flag_clr_o (flag_clr),
        .rdata_o    (bus_rdata_o)
    );

    tmr_dir_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .center_i   (ctrl.center != 2'b00),
        .down_sel_i (ctrl.down),
        .sw_upd_i   (sw_upd),
        .hit_top_i  (hit_top),
        .hit_bot_i  (hit_bot),
        .state_o    (state),
        .down_o     (down)
    );

    tmr_core #(.CNT_W(CNT_W), .REP_W(REP_W)) u_core (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick_i     (tick_i),
        .run_i      (ctrl.run),
        .center_i   (ctrl.center),
        .down_sel_i (ctrl.down),
        .preload_i  (ctrl.preload),
        .upd_off_i  (ctrl.upd_off),
        .quiet_i    (ctrl.quiet_sw),
        .reload_i   (reload),
        .repeat_i   (rep_val),
        .sw_upd_i   (sw_upd),
        .flag_clr_i (flag_clr),
        .state_i    (state),
        .cnt_o      (cnt),
        .hit_top_o  (hit_top),
        .hit_bot_o  (hit_bot),
        .uev_o      (uev_o),
        .flag_o     (flag),
        .psc_clr_o  (psc_clr_o)
    );

    assign cnt_o   = cnt;
    assign dir_o   = down;
    assign uflag_o = flag;
    assign irq_o   = flag & ctrl.irq_en;

    // R11: the interrupt never rises without a set flag
    a_r11_irq_needs_flag: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> uflag_o);

endmodule

// File: tb/tb_tmr_timebase.sv
`timescale 1ns/1ps
module tb_tmr_timebase;

    localparam int CW = 8;
    localparam int RW = 4;
    localparam int AW = 3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          tick = 1'b0;
    logic          we = 1'b0;
    logic [AW-1:0] wa = '0;
    logic [AW-1:0] ra = '0;
    logic [CW-1:0] wd = '0;
    logic [CW-1:0] rd, cnt;
    logic          dir, uev, flag, irq, pclr;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    typedef struct {
        int req;
        int c;
        bit u;
        bit f;
        bit d;
        bit i;
    } exp_t;

    exp_t q[$];

    always #2 clk = ~clk;

    tmr_timebase #(.CNT_W(CW), .REP_W(RW), .ADDR_W(AW)) dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .tick_i      (tick),
        .bus_we_i    (we),
        .bus_waddr_i (wa),
        .bus_wdata_i (wd),
        .bus_raddr_i (ra),
        .bus_rdata_o (rd),
        .cnt_o       (cnt),
        .dir_o       (dir),
        .uev_o       (uev),
        .uflag_o     (flag),
        .irq_o       (irq),
        .psc_clr_o   (pclr)
    );

    // Monitor: pops expectations and compares away from the clock edge.
    initial begin
        forever begin
            @(negedge clk);
            #1;
            while (q.size() > 0) begin
                exp_t e;
                e = q.pop_front();
                checks++;
                if (cnt !== CW'(e.c) || uev !== e.u || flag !== e.f ||
                    dir !== e.d || irq !== e.i) begin
                    errors++;
                    $display("FAIL R%0d: got cnt=%0d uev=%0b flag=%0b dir=%0b irq=%0b, expected cnt=%0d uev=%0b flag=%0b dir=%0b irq=%0b",
                             e.req, cnt, uev, flag, dir, irq, e.c, e.u, e.f, e.d, e.i);
                end
            end
        end
    end

    task automatic push(input int req, input int c, input bit u, input bit f,
                        input bit d, input bit i);
        exp_t e;
        e.req = req; e.c = c; e.u = u; e.f = f; e.d = d; e.i = i;
        q.push_back(e);
    endtask

    task automatic chk(input int req, input int got, input int want);
        checks++;
        if (got != want) begin
            errors++;
            $display("FAIL R%0d: got %0d expected %0d", req, got, want);
        end
    endtask

    // Driver: one clock of stimulus, called at a falling edge.
    task automatic cycle(input bit tk, input bit w, input int a, input int d);
        tick = tk;
        we   = w;
        wa   = AW'(a);
        wd   = CW'(d);
        @(negedge clk);
        tick = 1'b0;
        we   = 1'b0;
    endtask

    task automatic ticks(input int n);
        for (int k = 0; k < n; k++) cycle(1, 0, 0, 0);
    endtask

    task automatic clear_flag();
        cycle(0, 1, 4, 1);
    endtask

    initial begin
        #800000;
        if (!finished) begin
            errors++;
            $display("FAIL watchdog: got hung run, expected completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state
        push(1, 0, 0, 0, 0, 0);
        ra = 3'd5; #1; chk(12, rd, 0);          // R12 counter readback
        ra = 3'd1; #1; chk(1, rd, 255);         // R1 reload resets to all ones

        // R2: ticks ignored while run bit is 0
        for (int k = 0; k < 3; k++) begin
            cycle(1, 0, 0, 0);
            push(2, 0, 0, 0, 0, 0);
        end
        cycle(0, 1, 1, 3);
        cycle(0, 1, 0, 'h81);
        push(2, 0, 0, 0, 0, 0);

        // R3: up count 0..3 then wrap with event
        for (int k = 1; k <= 3; k++) begin
            cycle(1, 0, 0, 0);
            push(3, k, 0, 0, 0, 0);
        end
        cycle(1, 0, 0, 0);
        push(3, 0, 1, 1, 0, 1);
        cycle(0, 0, 0, 0);
        push(11, 0, 0, 1, 0, 1);                // R11 sticky, pulse one cycle
        clear_flag();
        push(11, 0, 0, 0, 0, 0);

        // R11: set beats a simultaneous clear
        ticks(3);
        cycle(1, 1, 4, 1);
        push(11, 0, 1, 1, 0, 1);
        clear_flag();
        push(11, 0, 0, 0, 0, 0);

        // R9 forced update in up mode, then R6 repetition of 2
        cycle(0, 1, 2, 2);
        cycle(0, 1, 3, 1);
        push(9, 0, 1, 1, 0, 1);
        #1; chk(9, pclr, 1);
        clear_flag();
        for (int w = 1; w <= 3; w++) begin
            ticks(3);
            cycle(1, 0, 0, 0);
            push(6, 0, w == 3, w == 3, 0, w == 3);
        end
        clear_flag();
        cycle(0, 1, 2, 0);
        cycle(0, 1, 3, 1);
        clear_flag();
        push(6, 0, 0, 0, 0, 0);

        // R7: deferred reload with preload on
        cycle(0, 1, 0, 'h91);
        cycle(0, 1, 1, 5);
        ticks(3);
        push(7, 3, 0, 0, 0, 0);
        cycle(1, 0, 0, 0);
        push(7, 0, 1, 1, 0, 1);
        clear_flag();
        ticks(5);
        push(7, 5, 0, 0, 0, 0);
        cycle(1, 0, 0, 0);
        push(7, 0, 1, 1, 0, 1);
        clear_flag();
        // R7: immediate reload with preload off
        cycle(0, 1, 0, 'h81);
        ticks(3);
        cycle(0, 1, 1, 2);
        cycle(1, 0, 0, 0);
        push(7, 0, 1, 1, 0, 1);
        clear_flag();

        // R8: update disable keeps old period and raises nothing
        cycle(0, 1, 0, 'hB1);
        cycle(0, 1, 1, 4);
        for (int w = 0; w < 2; w++) begin
            ticks(2);
            push(8, 2, 0, 0, 0, 0);
            cycle(1, 0, 0, 0);
            push(8, 0, 0, 0, 0, 0);
        end
        cycle(0, 1, 0, 'h91);
        ticks(2);
        cycle(1, 0, 0, 0);
        push(8, 0, 1, 1, 0, 1);
        clear_flag();
        ticks(4);
        push(8, 4, 0, 0, 0, 0);
        cycle(1, 0, 0, 0);
        push(8, 0, 1, 1, 0, 1);
        clear_flag();

        // R10: quiet forced update reloads but leaves flag clear
        cycle(0, 1, 0, 'hD1);
        cycle(0, 1, 1, 1);
        cycle(0, 1, 3, 1);
        push(10, 0, 1, 0, 0, 0);
        cycle(1, 0, 0, 0);
        push(10, 1, 0, 0, 0, 0);
        cycle(1, 0, 0, 0);
        push(10, 0, 1, 1, 0, 1);
        clear_flag();

        // R4: down mode
        cycle(0, 1, 0, 'h83);
        cycle(0, 1, 1, 3);
        push(4, 0, 0, 0, 1, 0);
        cycle(0, 1, 3, 1);
        push(9, 3, 1, 1, 1, 1);                 // R9 restart at reload when down
        clear_flag();
        for (int k = 2; k >= 0; k--) begin
            cycle(1, 0, 0, 0);
            push(4, k, 0, 0, 1, 0);
        end
        cycle(1, 0, 0, 0);
        push(4, 3, 1, 1, 1, 1);
        clear_flag();
        // R7: down wrap with preload uses the new value at once
        cycle(0, 1, 0, 'h93);
        cycle(0, 1, 1, 5);
        ticks(3);
        push(7, 0, 0, 0, 1, 0);
        cycle(1, 0, 0, 0);
        push(7, 5, 1, 1, 1, 1);
        clear_flag();

        // R5: centre mode, down bit set but ignored
        cycle(0, 1, 0, 'h87);
        cycle(0, 1, 1, 3);
        cycle(0, 1, 3, 1);
        push(5, 0, 1, 1, 0, 1);
        clear_flag();
        for (int k = 1; k <= 3; k++) begin
            cycle(1, 0, 0, 0);
            push(5, k, 0, 0, 0, 0);
        end
        cycle(1, 0, 0, 0);
        push(5, 2, 1, 1, 1, 1);
        cycle(1, 0, 0, 0);
        push(5, 1, 0, 1, 1, 1);
        ra = 3'd0; #1; chk(12, rd, 'h87);       // R12 direction bit shows down
        cycle(1, 0, 0, 0);
        push(5, 0, 0, 1, 1, 1);
        cycle(1, 0, 0, 0);
        push(5, 1, 1, 1, 0, 1);
        ra = 3'd0; #1; chk(12, rd, 'h85);       // R12 direction bit shows up
        cycle(1, 0, 0, 0);
        push(5, 2, 0, 1, 0, 1);
        cycle(0, 1, 3, 1);
        push(9, 0, 1, 1, 0, 1);                 // R9 restart at zero in centre
        clear_flag();

        // R3: full-width reload boundary
        cycle(0, 1, 0, 'h81);
        cycle(0, 1, 1, 255);
        cycle(0, 1, 3, 1);
        clear_flag();
        push(3, 0, 0, 0, 0, 0);
        ticks(255);
        push(3, 255, 0, 0, 0, 0);
        cycle(1, 0, 0, 0);
        push(3, 0, 1, 1, 0, 1);
        ra = 3'd4; #1; chk(12, rd, 1);          // R12 flag readback
        ra = 3'd1; #1; chk(12, rd, 255);
        ra = 3'd2; #1; chk(12, rd, 0);

        cycle(0, 0, 0, 0);
        @(negedge clk);
        #2;
        finished = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule